// File: doc/BRIEF.md
# I2C Controller Address Phase Sequencer

This block runs the addressing part of an I2C controller transaction on top of a byte-level bus engine. A start pulse captures a target address, a read/write request and an addressing-mode select. The block then issues one command at a time to the engine: generate a START, generate a REPEATED START, shift out a byte, or hand over to the data phase. It advances only when the engine reports that the current command has completed.

With 7-bit addressing a single byte goes out after the START. With 10-bit addressing a two-byte header follows the START. A read adds a REPEATED START and a resent first header byte with the read bit set. A NACK from the target on any address byte ends the sequence with an error pulse and a request for a STOP. STOP generation itself, the data bytes and bit timing belong to other blocks.

Top module: `i2c_addr_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `cmd_valid_o`, `done_o`, `nack_err_o` and `stop_req_o` are all low.
- R2: A `start_i` pulse while idle makes `busy_o` high and presents `cmd_o`=0 (START) on the next cycle. A `start_i` pulse while busy has no effect.
- R3: In 7-bit mode (`mode10_i`=0), after the START completes, `cmd_o`=2 (send byte) presents `tx_byte_o` = {addr[6:0], rnw}, where rnw is 1 for read and 0 for write. Address bits 9:7 are ignored.
- R4: In 10-bit mode the first byte after START is {5'b11110, addr[9], addr[8], 1'b0}.
- R5: In 10-bit mode the second byte is addr[7:0]. For a write the sequence completes directly after it is acknowledged.
- R6: For a 10-bit read, after the second byte is acknowledged, `cmd_o`=1 (REPEATED START) is presented. Once it completes, the byte {5'b11110, addr[9], addr[8], 1'b1} is sent.
- R7: Completion is one cycle with `cmd_valid_o`=1, `cmd_o`=3 (begin data phase), `done_o`=1 and `rd_dir_o` equal to the requested rnw. `busy_o` falls on the following cycle.
- R8: `ack_i`=0 with `byte_done_i` on any address byte produces one cycle of `nack_err_o`=1 and `stop_req_o`=1, with no data-phase command. `busy_o` then falls.
- R9: Exactly one command is outstanding. `cmd_o` and `tx_byte_o` hold until the matching strobe arrives: `cond_done_i` for START/REPEATED START, `byte_done_i` for a byte. The other strobe is ignored.
- R10: Address, mode and direction are captured at the accepted start pulse. Later changes on those inputs do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mode10_i | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| rnw_i | input | 1 | 1 read, 0 write |
| addr_i | input | 10 | Target address (bits 6:0 used in 7-bit mode) |
| byte_done_i | input | 1 | Engine finished shifting a byte |
| ack_i | input | 1 | Acknowledge sampled with `byte_done_i` (1 = ACK) |
| cond_done_i | input | 1 | Engine finished a START or REPEATED START |
| cmd_valid_o | output | 1 | A command is presented |
| cmd_o | output | 2 | 0 START, 1 REPEATED START, 2 send byte, 3 begin data phase |
| tx_byte_o | output | 8 | Byte to send when `cmd_o`=2 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Address phase finished successfully |
| rd_dir_o | output | 1 | Direction of the data phase, valid with `done_o` |
| nack_err_o | output | 1 | Address byte was not acknowledged |
| stop_req_o | output | 1 | Request to the engine to issue a STOP |

## Verification
The sequence is driven through 7-bit write and read, 10-bit write and 10-bit read. Together these separate the single-byte path, the two-byte header path and the extra REPEATED START re-address. Address values set the bits that each format should drop: 7-bit reads have bits 9:7 set, and 10-bit addresses have distinct bits 9 and 8. Each format therefore shows whether it picks the correct slice. NACKs are injected on the first, second and resent header bytes. Off-state strobes, start pulses during a sequence and input changes after capture show that only the matching strobe moves the sequence.

// File: rtl/i2c_addr_seq_pkg.sv
package i2c_addr_seq_pkg;

    localparam int ADDR_W   = 10;
    localparam int BYTE_W   = 8;
    localparam int A7_W     = 7;
    localparam int PFX_W    = 5;
    localparam logic [PFX_W-1:0] TENBIT_PFX = 5'b11110;

    typedef enum logic [1:0] {
        CMD_START  = 2'd0,
        CMD_RSTART = 2'd1,
        CMD_SEND   = 2'd2,
        CMD_DATA   = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COND_S,
        ST_BYTE_A,
        ST_BYTE_B,
        ST_COND_R,
        ST_BYTE_C,
        ST_DONE,
        ST_ABORT
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        logic              mode10;
        logic              rnw;
        logic [ADDR_W-1:0] addr;
    } seq_regs_t;

endpackage

// File: rtl/i2c_addr_hdr_fmt.sv
module i2c_addr_hdr_fmt
    import i2c_addr_seq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              mode10,
    input  logic              rnw,
    output logic [BYTE_W-1:0] first_byte,
    output logic [BYTE_W-1:0] second_byte,
    output logic [BYTE_W-1:0] resend_byte
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [BYTE_W-1:0] seven_byte;
    logic [BYTE_W-1:0] ten_first;

    always_comb begin
        seven_byte  = {addr[A7_W-1:0], rnw};
        ten_first   = {TENBIT_PFX, addr[ADDR_W-1 -: HI_W], 1'b0};
        first_byte  = mode10 ? ten_first : seven_byte;
        second_byte = addr[BYTE_W-1:0];
        resend_byte = {TENBIT_PFX, addr[ADDR_W-1 -: HI_W], 1'b1};
    end

endmodule

// File: rtl/i2c_addr_cmd_dec.sv
module i2c_addr_cmd_dec
    import i2c_addr_seq_pkg::*;
(
    input  seq_state_e        state,
    input  logic              rnw,
    input  logic [BYTE_W-1:0] first_byte,
    input  logic [BYTE_W-1:0] second_byte,
    input  logic [BYTE_W-1:0] resend_byte,
    output logic              cmd_valid,
    output logic [1:0]        cmd,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              busy,
    output logic              done,
    output logic              rd_dir,
    output logic              nack_err,
    output logic              stop_req
);
    always_comb begin
        cmd_valid = 1'b1;
        cmd       = CMD_SEND;
        tx_byte   = '0;
        busy      = 1'b1;
        done      = 1'b0;
        rd_dir    = 1'b0;
        nack_err  = 1'b0;
        stop_req  = 1'b0;
        case (state)
            ST_IDLE: begin
                cmd_valid = 1'b0;
                busy      = 1'b0;
            end
            ST_COND_S: cmd = CMD_START;
            ST_BYTE_A: tx_byte = first_byte;
            ST_BYTE_B: tx_byte = second_byte;
            ST_COND_R: cmd = CMD_RSTART;
            ST_BYTE_C: tx_byte = resend_byte;
            ST_DONE: begin
                cmd    = CMD_DATA;
                done   = 1'b1;
                rd_dir = rnw;
            end
            ST_ABORT: begin
                cmd_valid = 1'b0;
                nack_err  = 1'b1;
                stop_req  = 1'b1;
            end
            default: begin
                cmd_valid = 1'b0;
                busy      = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
    import i2c_addr_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        mode10_i,
    input  logic        rnw_i,
    input  logic [9:0]  addr_i,
    input  logic        byte_done_i,
    input  logic        ack_i,
    input  logic        cond_done_i,
    output logic        cmd_valid_o,
    output logic [1:0]  cmd_o,
    output logic [7:0]  tx_byte_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        rd_dir_o,
    output logic        nack_err_o,
    output logic        stop_req_o
);
    seq_regs_t regs_d, regs_q;

    logic [BYTE_W-1:0] first_byte;
    logic [BYTE_W-1:0] second_byte;
    logic [BYTE_W-1:0] resend_byte;

    i2c_addr_hdr_fmt u_fmt (
        .addr        (regs_q.addr),
        .mode10      (regs_q.mode10),
        .rnw         (regs_q.rnw),
        .first_byte  (first_byte),
        .second_byte (second_byte),
        .resend_byte (resend_byte)
    );

    always_comb begin
        regs_d = regs_q;
        case (regs_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    regs_d.state  = ST_COND_S;
                    regs_d.mode10 = mode10_i;
                    regs_d.rnw    = rnw_i;
                    regs_d.addr   = addr_i;
                end
            end
            ST_COND_S: begin
                if (cond_done_i) regs_d.state = ST_BYTE_A;
            end
            ST_BYTE_A: begin
                if (byte_done_i) begin
                    if (!ack_i)             regs_d.state = ST_ABORT;
                    else if (regs_q.mode10) regs_d.state = ST_BYTE_B;
                    else                    regs_d.state = ST_DONE;
                end
            end
            ST_BYTE_B: begin
                if (byte_done_i) begin
                    if (!ack_i)          regs_d.state = ST_ABORT;
                    else if (regs_q.rnw) regs_d.state = ST_COND_R;
                    else                 regs_d.state = ST_DONE;
                end
            end
            ST_COND_R: begin
                if (cond_done_i) regs_d.state = ST_BYTE_C;
            end
            ST_BYTE_C: begin
                if (byte_done_i) regs_d.state = ack_i ? ST_DONE : ST_ABORT;
            end
            ST_DONE:  regs_d.state = ST_IDLE;
            ST_ABORT: regs_d.state = ST_IDLE;
            default:  regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_IDLE, mode10: 1'b0, rnw: 1'b0, addr: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    i2c_addr_cmd_dec u_dec (
        .state       (regs_q.state),
        .rnw         (regs_q.rnw),
        .first_byte  (first_byte),
        .second_byte (second_byte),
        .resend_byte (resend_byte),
        .cmd_valid   (cmd_valid_o),
        .cmd         (cmd_o),
        .tx_byte     (tx_byte_o),
        .busy        (busy_o),
        .done        (done_o),
        .rd_dir      (rd_dir_o),
        .nack_err    (nack_err_o),
        .stop_req    (stop_req_o)
    );

endmodule

// File: rtl/i2c_addr_seq_chk.sv
module i2c_addr_seq_chk
    import i2c_addr_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       byte_done_i,
    input logic       ack_i,
    input logic       cond_done_i,
    input logic       cmd_valid_o,
    input logic [1:0] cmd_o,
    input logic [7:0] tx_byte_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       nack_err_o,
    input logic       stop_req_o
);
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && cmd_valid_o && cmd_o == CMD_START)); // R2

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o != CMD_DATA && !byte_done_i && !cond_done_i)
        |=> (cmd_valid_o && $stable(cmd_o) && $stable(tx_byte_o))); // R9

    AST_NACK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o == CMD_SEND && byte_done_i && !ack_i)
        |=> (nack_err_o && stop_req_o && !done_o)); // R8

    AST_DATA_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o == CMD_DATA) |-> done_o); // R7

    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o || nack_err_o)); // R7

    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && nack_err_o)); // R8

endmodule

bind i2c_addr_seq i2c_addr_seq_chk u_chk (.*);

// File: tb/i2c_addr_seq_bench.sv
`timescale 1ns/1ps
module i2c_addr_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       mode10_i = 1'b0;
    logic       rnw_i = 1'b0;
    logic [9:0] addr_i = '0;
    logic       byte_done_i = 1'b0;
    logic       ack_i = 1'b0;
    logic       cond_done_i = 1'b0;
    logic       cmd_valid_o;
    logic [1:0] cmd_o;
    logic [7:0] tx_byte_o;
    logic       busy_o, done_o, rd_dir_o, nack_err_o, stop_req_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    i2c_addr_seq u_i2c_addr_seq (.*);

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_start(input bit m10, input bit rd, input logic [9:0] a);
        mode10_i = m10; rnw_i = rd; addr_i = a; start_i = 1'b1;
        tick();
        start_i = 1'b0;
    endtask

    task automatic strobe_byte(input bit ack);
        byte_done_i = 1'b1; ack_i = ack;
        tick();
        byte_done_i = 1'b0; ack_i = 1'b0;
    endtask

    task automatic strobe_cond();
        cond_done_i = 1'b1;
        tick();
        cond_done_i = 1'b0;
    endtask

    task automatic expect_cmd(input string req, input int c, input int b);
        check(req, "cmd_valid", cmd_valid_o, 1);
        check(req, "cmd", cmd_o, c);
        check(req, "busy", busy_o, 1);
        if (c == 2) check(req, "tx_byte", tx_byte_o, b);
    endtask

    task automatic expect_done(input string req, input bit rd);
        check(req, "done cmd", cmd_o, 3);
        check(req, "done valid", cmd_valid_o, 1);
        check(req, "done", done_o, 1);
        check(req, "rd_dir", rd_dir_o, rd);
        check(req, "no err at done", nack_err_o, 0);
        tick();
        check("R7", "busy after done", busy_o, 0);
        check("R7", "valid after done", cmd_valid_o, 0);
    endtask

    task automatic expect_abort(input string req);
        check(req, "nack_err", nack_err_o, 1);
        check(req, "stop_req", stop_req_o, 1);
        check(req, "no done", done_o, 0);
        check(req, "no cmd", cmd_valid_o, 0);
        tick();
        check(req, "busy after abort", busy_o, 0);
        check(req, "err cleared", nack_err_o, 0);
    endtask

    task automatic t_reset();
        check("R1", "busy", busy_o, 0);
        check("R1", "cmd_valid", cmd_valid_o, 0);
        check("R1", "done", done_o, 0);
        check("R1", "nack_err", nack_err_o, 0);
        check("R1", "stop_req", stop_req_o, 0);
    endtask

    task automatic t_w7();
        do_start(1'b0, 1'b0, 10'h02A);
        expect_cmd("R2", 0, 0);
        strobe_cond();
        expect_cmd("R3", 2, 8'h54);
        strobe_byte(1'b1);
        expect_done("R7", 1'b0);
    endtask

    task automatic t_r7_upper();
        do_start(1'b0, 1'b1, 10'h3C5);
        expect_cmd("R2", 0, 0);
        strobe_cond();
        expect_cmd("R3", 2, 8'h8B);
        strobe_byte(1'b1);
        expect_done("R7", 1'b1);
    endtask

    task automatic t_w10();
        do_start(1'b1, 1'b0, 10'h2B7);
        strobe_cond();
        expect_cmd("R4", 2, 8'hF4);
        strobe_byte(1'b1);
        expect_cmd("R5", 2, 8'hB7);
        strobe_byte(1'b1);
        expect_done("R5", 1'b0);
    endtask

    task automatic t_r10();
        do_start(1'b1, 1'b1, 10'h1A5);
        strobe_cond();
        expect_cmd("R4", 2, 8'hF2);
        strobe_byte(1'b1);
        expect_cmd("R5", 2, 8'hA5);
        strobe_byte(1'b1);
        expect_cmd("R6", 1, 0);
        strobe_cond();
        expect_cmd("R6", 2, 8'hF3);
        strobe_byte(1'b1);
        expect_done("R6", 1'b1);
    endtask

    task automatic t_nack(input int stage);
        do_start(1'b1, 1'b1, 10'h0F0);
        strobe_cond();
        if (stage == 0) begin
            strobe_byte(1'b0);
            expect_abort("R8");
            return;
        end
        strobe_byte(1'b1);
        if (stage == 1) begin
            strobe_byte(1'b0);
            expect_abort("R8");
            return;
        end
        strobe_byte(1'b1);
        strobe_cond();
        expect_cmd("R6", 2, 8'hF1);
        strobe_byte(1'b0);
        expect_abort("R8");
    endtask

    task automatic t_busy_ignore();
        do_start(1'b0, 1'b0, 10'h011);
        do_start(1'b1, 1'b1, 10'h3FF);
        expect_cmd("R2", 0, 0);
        strobe_cond();
        expect_cmd("R2", 2, 8'h22);
        strobe_byte(1'b1);
        expect_done("R2", 1'b0);
    endtask

    task automatic t_wrong_strobe();
        do_start(1'b1, 1'b0, 10'h155);
        strobe_byte(1'b0);
        expect_cmd("R9", 0, 0);
        check("R9", "no err from byte strobe in START", nack_err_o, 0);
        strobe_cond();
        expect_cmd("R9", 2, 8'hF2);
        strobe_cond();
        expect_cmd("R9", 2, 8'hF2);
        tick();
        expect_cmd("R9", 2, 8'hF2);
        strobe_byte(1'b1);
        expect_cmd("R9", 2, 8'h55);
        strobe_byte(1'b1);
        expect_done("R9", 1'b0);
    endtask

    task automatic t_latch();
        do_start(1'b1, 1'b1, 10'h2C3);
        mode10_i = 1'b0; rnw_i = 1'b0; addr_i = 10'h000;
        strobe_cond();
        expect_cmd("R10", 2, 8'hF4);
        strobe_byte(1'b1);
        expect_cmd("R10", 2, 8'hC3);
        strobe_byte(1'b1);
        expect_cmd("R10", 1, 0);
        strobe_cond();
        expect_cmd("R10", 2, 8'hF5);
        strobe_byte(1'b1);
        expect_done("R10", 1'b1);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_w7();
        t_r7_upper();
        t_w10();
        t_r10();
        t_nack(0);
        t_nack(1);
        t_nack(2);
        t_busy_ignore();
        t_wrong_strobe();
        t_latch();
        tick();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule